// File: doc/BRIEF.md
# Serial Transmit/Receive Engine with Selectable Character Size

The engine turns a parallel word into a serial frame on `txd` and turns frames seen on `rxd` back into words. Each frame has a low start bit, five to nine data bits sent least significant bit first, and a high stop bit. Between frames the line sits high. A 3-bit size code sets the character length, and the transmitter and receiver both follow it. The transmitter captures the code when it takes a word and the receiver captures it when it sees a start bit.

A 12-bit divisor sets the rate. A base tick fires once every `baudDiv+1` clock cycles. In asynchronous mode a bit lasts sixteen ticks, and the receiver oversamples and takes the value in the middle of each bit. In synchronous master mode the engine drives a continuous serial clock `sclk` that toggles on every tick. A polarity input chooses which `sclk` edge launches transmit bits and which edge samples received bits.

Words enter through a valid/ready handshake and leave through another. The receive side holds one word. A reserved size code makes the engine run with eight bits and sets a sticky error flag.

Top module: `usart_engine`

## Requirements
- R1: Size codes map to data bits as follows: 000 gives 5, 001 gives 6, 010 gives 7, 011 gives 8 and 111 gives 9. The transmitter and the receiver both use the mapped count.
- R2: Codes 100, 101 and 110 run as 8 data bits. Any clock edge that sees one of these codes sets `cfgErr`, which then stays high until reset.
- R3: A frame on `txd` is a start bit at 0, then the data bits LSB first, then a stop bit at 1. `txReady` is high only when no frame is pending. `txd` is 1 whenever `txReady` is high. A word is accepted on an edge where `txValid` and `txReady` are both high.
- R4: In asynchronous mode the base tick fires once every `baudDiv+1` cycles. `txd` changes only on every sixteenth tick, so each bit lasts 16×(`baudDiv+1`) cycles.
- R5: In synchronous mode `sclk` toggles on every tick, giving a period of 2×(`baudDiv+1`) cycles. It starts at level `clkPol` after reset and is held at 0 in asynchronous mode.
- R6: In synchronous mode each transmitted bit lasts one `sclk` period. With `clkPol`=0, `txd` changes on the rising edge of `sclk` and `rxd` is sampled on the falling edge; with `clkPol`=1 the two edges swap. For looped-back data `baudDiv` must be at least 2.
- R7: In asynchronous mode the receiver looks for a low `rxd` (passed through a 2-stage synchronizer) on each tick. It samples the start bit 8 ticks later and every 16 ticks after that. If the start sample is high, the receiver drops back to idle.
- R8: `rxData` is 9 bits wide. In 9-bit mode bit 8 carries the ninth data bit. Bits at and above the character size read 0. `rxValid` stays high until `rxReady` is seen. A newer word replaces one that has not been taken.
- R9: If the stop bit is sampled low, `rxFerr` is 1 alongside the word; otherwise it is 0.
- R10: `baudDiv` uses all 12 bits. During reset `txd`=1, `txReady`=1, `rxValid`=0 and `cfgErr`=0, and `sclk` equals `clkPol` in synchronous mode or 0 in asynchronous mode.
- R11: Transmit data bits at and above the character size are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| syncMode | input | 1 | 1 = synchronous master, 0 = asynchronous |
| clkPol | input | 1 | Serial clock polarity (synchronous mode only) |
| baudDiv | input | 12 | Rate divisor; tick every baudDiv+1 cycles |
| sizeCode | input | 3 | Character size code |
| txData | input | 9 | Word to transmit |
| txValid | input | 1 | txData is valid |
| txReady | output | 1 | Transmitter can take a word |
| txd | output | 1 | Serial transmit line |
| sclk | output | 1 | Serial clock in synchronous mode |
| rxd | input | 1 | Serial receive line |
| rxData | output | 9 | Received word |
| rxValid | output | 1 | rxData holds an unclaimed word |
| rxReady | input | 1 | Consumer takes rxData |
| rxFerr | output | 1 | Stop bit of rxData was sampled low |
| cfgErr | output | 1 | Sticky reserved-size-code flag |

## Verification
The assertions run on every cycle. They check that the line is high whenever the transmitter is ready, and that in synchronous mode `txd` changes only on the launch edge chosen by `clkPol`. They also check that an unclaimed word stays valid, that unused high bits of `rxData` are zero, and that the configuration error is raised and then held. The bench scenarios cover the rest: the exact bit duration for a given divisor, the mid-bit sampling point, rejection of a false start, framing errors, replacement of an unclaimed word, and each character size end to end over a loopback.

// File: rtl/usart_pkg.sv
package usart_pkg;
  localparam int MaxBits = 9;

  // Timing strobes handed from the control half to the datapath
  typedef struct packed {
    logic tick;      // base rate tick
    logic txBit;     // move the transmitter to its next bit
    logic rxSample;  // synchronous-mode sample edge
  } strobe_t;

  function automatic logic [3:0] charBits(input logic [2:0] code);
    case (code)
      3'b000:  return 4'd5;
      3'b001:  return 4'd6;
      3'b010:  return 4'd7;
      3'b111:  return 4'd9;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic isReserved(input logic [2:0] code);
    return (code == 3'b100) || (code == 3'b101) || (code == 3'b110);
  endfunction
endpackage

// File: rtl/usart_ctrl.sv
module usart_ctrl
  import usart_pkg::*;
#(
  parameter int DivW = 12,
  parameter int Oversample = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            syncMode,
  input  logic            clkPol,
  input  logic [DivW-1:0] baudDiv,
  output strobe_t         stb,
  output logic            sclk
);
  localparam int SubW = $clog2(Oversample);

  logic [DivW-1:0] preCnt;
  logic [SubW-1:0] subCnt;
  logic            phase;
  logic            tick;

  assign tick = (preCnt >= baudDiv);

  always_ff @(posedge clk) begin
    if (rst) begin
      preCnt <= '0;
      subCnt <= '0;
      phase  <= 1'b0;
    end else if (tick) begin
      preCnt <= '0;
      subCnt <= subCnt + 1'b1;
      phase  <= syncMode ? ~phase : 1'b0;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  always_comb begin
    stb.tick     = tick;
    stb.txBit    = tick && (syncMode ? !phase : (subCnt == SubW'(Oversample - 1)));
    stb.rxSample = tick && syncMode && phase;
  end

  assign sclk = syncMode ? (phase ^ clkPol) : 1'b0;
endmodule

// File: rtl/usart_dp.sv
module usart_dp
  import usart_pkg::*;
#(
  parameter int Oversample = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  strobe_t            stb,
  input  logic               syncMode,
  input  logic [2:0]         sizeCode,
  input  logic [MaxBits-1:0] txData,
  input  logic               txValid,
  output logic               txReady,
  output logic               txd,
  input  logic               rxd,
  output logic [MaxBits-1:0] rxData,
  output logic               rxValid,
  input  logic               rxReady,
  output logic               rxFerr,
  output logic               cfgErr
);
  localparam int FrameW = MaxBits + 2;
  localparam int SubW   = $clog2(Oversample);
  localparam logic [SubW-1:0] MidPoint = SubW'(Oversample / 2 - 1);

  logic [3:0]        nBits;
  logic [FrameW-1:0] frameVec, txShift;
  logic [3:0]        txLeft;
  logic              accept;

  assign nBits   = charBits(sizeCode);
  assign txReady = (txLeft == '0);
  assign accept  = txValid && txReady;

  always_comb begin
    frameVec    = '1;
    frameVec[0] = 1'b0;
    for (int i = 0; i < MaxBits; i++)
      if (4'(i) < nBits) frameVec[i+1] = txData[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txShift <= '1;
      txLeft  <= '0;
      txd     <= 1'b1;
    end else if (accept) begin
      txShift <= frameVec;
      txLeft  <= nBits + 4'd2;
    end else if (stb.txBit && !txReady) begin
      txd     <= txShift[0];
      txShift <= {1'b1, txShift[FrameW-1:1]};
      txLeft  <= txLeft - 1'b1;
    end
  end

  logic               rxMeta, rxSync;
  logic               rxActive;
  logic [3:0]         rxIdx, rxBits;
  logic [SubW-1:0]    rxSub;
  logic [MaxBits-1:0] rxBuf;
  logic               startSeen, takeBit;

  assign startSeen = !rxActive && !rxSync && (syncMode ? stb.rxSample : stb.tick);
  assign takeBit   = rxActive && (syncMode ? stb.rxSample : (stb.tick && rxSub == MidPoint));

  always_ff @(posedge clk) begin
    if (rst) begin
      rxMeta   <= 1'b1;
      rxSync   <= 1'b1;
      rxActive <= 1'b0;
      rxIdx    <= '0;
      rxBits   <= '0;
      rxSub    <= '0;
      rxBuf    <= '0;
      rxData   <= '0;
      rxValid  <= 1'b0;
      rxFerr   <= 1'b0;
      cfgErr   <= 1'b0;
    end else begin
      rxMeta <= rxd;
      rxSync <= rxMeta;
      if (isReserved(sizeCode)) cfgErr <= 1'b1;
      if (rxValid && rxReady) rxValid <= 1'b0;
      if (startSeen) begin
        rxActive <= 1'b1;
        rxSub    <= '0;
        rxBits   <= nBits;
        rxBuf    <= '0;
        rxIdx    <= syncMode ? 4'd1 : 4'd0;
      end else if (rxActive) begin
        if (stb.tick && !syncMode) rxSub <= rxSub + 1'b1;
        if (takeBit) begin
          if (rxIdx == 4'd0) begin
            if (rxSync) rxActive <= 1'b0;
            else        rxIdx    <= 4'd1;
          end else if (rxIdx <= rxBits) begin
            for (int i = 0; i < MaxBits; i++)
              if (rxIdx == 4'(i + 1)) rxBuf[i] <= rxSync;
            rxIdx <= rxIdx + 1'b1;
          end else begin
            rxActive <= 1'b0;
            rxData   <= rxBuf;
            rxFerr   <= !rxSync;
            rxValid  <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/usart_engine.sv
module usart_engine
  import usart_pkg::*;
#(
  parameter int DivW = 12,
  parameter int Oversample = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               syncMode,
  input  logic               clkPol,
  input  logic [DivW-1:0]    baudDiv,
  input  logic [2:0]         sizeCode,
  input  logic [MaxBits-1:0] txData,
  input  logic               txValid,
  output logic               txReady,
  output logic               txd,
  output logic               sclk,
  input  logic               rxd,
  output logic [MaxBits-1:0] rxData,
  output logic               rxValid,
  input  logic               rxReady,
  output logic               rxFerr,
  output logic               cfgErr
);
  strobe_t stb;

  usart_ctrl #(.DivW(DivW), .Oversample(Oversample)) ctrl (
    .clk(clk), .rst(rst), .syncMode(syncMode), .clkPol(clkPol),
    .baudDiv(baudDiv), .stb(stb), .sclk(sclk)
  );

  usart_dp #(.Oversample(Oversample)) dp (
    .clk(clk), .rst(rst), .stb(stb), .syncMode(syncMode), .sizeCode(sizeCode),
    .txData(txData), .txValid(txValid), .txReady(txReady), .txd(txd),
    .rxd(rxd), .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady),
    .rxFerr(rxFerr), .cfgErr(cfgErr)
  );
endmodule

// File: rtl/usart_engine_chk.sv
module usart_engine_chk
  import usart_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               syncMode,
  input logic               clkPol,
  input logic [2:0]         sizeCode,
  input logic               txReady,
  input logic               txd,
  input logic               sclk,
  input logic [MaxBits-1:0] rxData,
  input logic               rxValid,
  input logic               rxReady,
  input logic               cfgErr
);
  // R3
  tx_idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    txReady |-> txd);

  // R6
  launch_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (syncMode && $stable(syncMode) && $stable(clkPol) && (txd != $past(txd)))
      |-> (sclk != clkPol) && ($past(sclk) == clkPol));

  // R8
  rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rxValid && !rxReady) |=> rxValid);

  // R8
  rx_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(rxValid) && $stable(sizeCode)) |-> ((rxData >> charBits(sizeCode)) == '0));

  // R2
  cfg_raise_chk: assert property (@(posedge clk) disable iff (rst)
    isReserved(sizeCode) |=> cfgErr);

  // R2
  cfg_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    cfgErr |=> cfgErr);
endmodule

bind usart_engine usart_engine_chk chk (
  .clk(clk), .rst(rst), .syncMode(syncMode), .clkPol(clkPol), .sizeCode(sizeCode),
  .txReady(txReady), .txd(txd), .sclk(sclk), .rxData(rxData), .rxValid(rxValid),
  .rxReady(rxReady), .cfgErr(cfgErr)
);

// File: tb/usart_engine_test.sv
module usart_engine_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst = 1'b1, syncMode = 1'b0, clkPol = 1'b0;
  logic [11:0] baudDiv = 12'd1;
  logic [2:0]  sizeCode = 3'b011;
  logic [8:0]  txData = '0;
  logic        txValid = 1'b0, txReady, txd, sclk;
  logic        rxdMan = 1'b1, rxReady = 1'b1;
  logic        rxValid, rxFerr, cfgErr;
  logic [8:0]  rxData;
  bit          loop = 1'b1;
  wire         rxd = loop ? txd : rxdMan;

  usart_engine uut (
    .clk(clk), .rst(rst), .syncMode(syncMode), .clkPol(clkPol), .baudDiv(baudDiv),
    .sizeCode(sizeCode), .txData(txData), .txValid(txValid), .txReady(txReady),
    .txd(txd), .sclk(sclk), .rxd(rxd), .rxData(rxData), .rxValid(rxValid),
    .rxReady(rxReady), .rxFerr(rxFerr), .cfgErr(cfgErr)
  );

  int nChk = 0, nFail = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  endtask

  function automatic int benchBits(input logic [2:0] c);
    case (c)
      3'b000: return 5;
      3'b001: return 6;
      3'b010: return 7;
      3'b111: return 9;
      default: return 8;
    endcase
  endfunction

  // Behavioural reference: bit queue, integer time base
  int  edgeNo, mDiv, kIdx, nb;
  bit  mq[$];
  int  rq[$];
  bit  mTxd = 1, mPhase = 0, tk, st;
  int  lastRx = 0;

  always @(posedge clk) begin
    if (rst) begin
      edgeNo = 0; mDiv = int'(baudDiv); mq.delete(); rq.delete(); mTxd = 1; mPhase = 0;
    end else begin
      edgeNo++;
      tk   = (edgeNo % (mDiv + 1)) == 0;
      kIdx = edgeNo / (mDiv + 1);
      st   = tk && (syncMode ? (kIdx % 2 == 1) : (kIdx % 16 == 0));
      if (mq.size() == 0 && txValid) begin
        nb = benchBits(sizeCode);
        mq.push_back(1'b0);
        for (int i = 0; i < nb; i++) mq.push_back(txData[i]);
        mq.push_back(1'b1);
        if (loop) rq.push_back(int'(txData) & ((1 << nb) - 1));
      end else if (st && mq.size() > 0) begin
        mTxd = mq.pop_front();
      end
      if (tk && syncMode) mPhase = kIdx[0];
    end
  end

  int expW;
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(txd === mTxd, syncMode ? "R6 txd launch" : "R4 txd bit time", txd, mTxd);
      check(txReady === (mq.size() == 0), "R3 txReady", txReady, mq.size() == 0);
      check(sclk === (syncMode ? (mPhase ^ clkPol) : 1'b0), "R5 sclk", sclk,
            syncMode ? (mPhase ^ clkPol) : 0);
      if (loop && rxValid && rxReady) begin
        if (rq.size() == 0) check(0, "R7 unexpected word", rxData, 0);
        else begin
          expW = rq.pop_front();
          check(int'(rxData) == expW && !rxFerr, syncMode ? "R6 rx word" : "R7 rx word",
                rxData, expW);
        end
        lastRx = int'(rxData);
      end
    end
  end

  task automatic doReset(input bit m, input bit p, input int d, input logic [2:0] s);
    @(negedge clk);
    rst = 1; syncMode = m; clkPol = p; baudDiv = 12'(d); sizeCode = s; txValid = 0;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic sendWord(input logic [8:0] w);
    while (!txReady) @(negedge clk);
    txData = w; txValid = 1;
    @(negedge clk);
    txValid = 0;
  endtask

  task automatic waitIdle();
    int guard = 0;
    while ((mq.size() != 0 || rq.size() != 0 || !txReady) && guard < 20000) begin
      @(negedge clk); guard++;
    end
    check(guard < 20000, "R3 frame completes", guard, 0);
  endtask

  task automatic runSize(input logic [2:0] c, input logic [8:0] w, input int exp, input string tag);
    sizeCode = c;
    sendWord(w);
    waitIdle();
    check(lastRx == exp, tag, lastRx, exp);
  endtask

  // 32 cycles per bit at baudDiv=1
  task automatic driveFrame(input logic [7:0] d, input bit stopv);
    rxdMan = 0; repeat (32) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxdMan = d[i]; repeat (32) @(negedge clk); end
    rxdMan = stopv; repeat (24) @(negedge clk);
    rxdMan = 1; repeat (60) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    // R10 reset state, asynchronous mode
    doReset(0, 0, 1, 3'b011);
    check(txd == 1, "R10 txd idle", txd, 1);
    check(txReady == 1, "R10 txReady", txReady, 1);
    check(rxValid == 0, "R10 rxValid", rxValid, 0);
    check(cfgErr == 0, "R10 cfgErr", cfgErr, 0);
    check(sclk == 0, "R10 sclk async", sclk, 0);

    // R3 R4 R7: 8-bit loopback
    sendWord(9'h0A5);
    sendWord(9'h03C);
    waitIdle();
    check(lastRx == 'h03C, "R8 8-bit word upper zero", lastRx, 'h03C);

    // R1 R11: sizes
    runSize(3'b000, 9'h1F3, 'h013, "R1 5-bit");
    runSize(3'b001, 9'h1FF, 'h03F, "R11 6-bit mask");
    runSize(3'b010, 9'h0AA, 'h02A, "R1 7-bit");
    runSize(3'b111, 9'h1A5, 'h1A5, "R8 9-bit bit8");

    // R2 reserved codes
    doReset(0, 0, 1, 3'b011);
    @(negedge clk);
    check(cfgErr == 0, "R2 clear", cfgErr, 0);
    sizeCode = 3'b101;
    @(negedge clk);
    check(cfgErr == 1, "R2 raise", cfgErr, 1);
    sizeCode = 3'b011;
    repeat (5) @(negedge clk);
    check(cfgErr == 1, "R2 sticky", cfgErr, 1);
    runSize(3'b110, 9'h1C3, 'h0C3, "R2 reserved as 8 bits");

    // R9 R8 R7: hand-driven receive
    loop = 0;
    doReset(0, 0, 1, 3'b011);
    rxReady = 0;
    driveFrame(8'h5A, 0);
    check(rxValid == 1, "R9 word valid", rxValid, 1);
    check(rxData == 9'h05A, "R9 data", rxData, 'h05A);
    check(rxFerr == 1, "R9 framing error", rxFerr, 1);
    repeat (20) @(negedge clk);
    check(rxValid == 1, "R8 hold until ready", rxValid, 1);
    driveFrame(8'h81, 1);
    check(rxData == 9'h081, "R8 overwrite", rxData, 'h081);
    check(rxFerr == 0, "R9 good stop", rxFerr, 0);
    rxReady = 1;
    @(negedge clk);
    check(rxValid == 0, "R8 taken", rxValid, 0);
    rxdMan = 0; repeat (4) @(negedge clk);
    rxdMan = 1; repeat (200) @(negedge clk);
    check(rxValid == 0, "R7 false start", rxValid, 0);
    rxReady = 0;
    driveFrame(8'h3C, 1);
    check(rxValid == 1 && rxData == 9'h03C, "R7 after abort", rxData, 'h03C);
    rxReady = 1;
    @(negedge clk);
    loop = 1;

    // R5 R6 synchronous, polarity 0
    doReset(1, 0, 3, 3'b011);
    check(sclk == 0, "R10 sync pol0 level", sclk, 0);
    sendWord(9'h096);
    sendWord(9'h041);
    waitIdle();
    check(lastRx == 'h041, "R6 pol0 word", lastRx, 'h041);

    // R6 synchronous, polarity 1, 9 bits
    doReset(1, 1, 2, 3'b111);
    check(sclk == 1, "R10 sync pol1 level", sclk, 1);
    sendWord(9'h155);
    waitIdle();
    check(lastRx == 'h155, "R6 pol1 9-bit", lastRx, 'h155);

    // R10 divisor above 8 bits
    doReset(1, 0, 12'h104, 3'b000);
    sendWord(9'h015);
    waitIdle();
    check(lastRx == 'h015, "R10 wide divisor", lastRx, 'h015);

    finishRun();
  end
endmodule